// File: doc/BRIEF.md
# Socket Status-Change Event Register

This block keeps a sticky record of changes on four status lines from a card socket. The lines are power cycle, two card-detect lines and the card's status-change line. They arrive asynchronously and are synchronized inside the block. An edge detector compares each line with its previous value. Any qualifying change sets an event bit, and that bit stays set until software clears it. Software reads the bits through a plain read port. It clears bits by writing ones to a clear port and can set bits by writing ones to a force port.

The card's status-change line is the only line whose edge rule depends on the inserted card. For a 32-bit card, only a rising transition counts. For a 16-bit card, both transitions count.

Two resets are involved. A global reset always wipes the event bits. A bus reset wipes them only while power-management events are disabled. In the cycle after the event bits come out of a clearing reset, the bits whose condition still holds are set again. Each event bit is combined with an interrupt enable, and the results drive a registered interrupt request.

Top module: `sock_evt_reg`

## Requirements
- R1: Bit positions: 0 is the status-change event, 1 is card-detect 1, 2 is card-detect 2 and 3 is power cycle. `stat_in` uses the same positions. `rd_data` bits 31..4 always read 0, and ones written there through either write port change nothing.
- R2: A change of either value on `stat_in[1]`, `stat_in[2]` or `stat_in[3]` sets the matching event bit. The bit is visible on `rd_data` after the third rising clock edge following the input change.
- R3: With `card_16b` = 0 (32-bit card), bit 0 is set only by a 0-to-1 transition of `stat_in[0]`. A 1-to-0 transition has no effect.
- R4: With `card_16b` = 1 (16-bit card), bit 0 is set by both transitions of `stat_in[0]`.
- R5: While `clr_we` is 1, each event bit whose `clr_data` bit is 1 is cleared at the next edge. Bits written with 0 are unchanged.
- R6: While `frc_we` is 1, each event bit whose `frc_data` bit is 1 is 1 after the next edge.
- R7: If a hardware set or a force set lands on a bit in the same cycle as a clear, the bit ends up 1.
- R8: `glb_rst` = 1 clears all event bits and `irq`. `bus_rst` = 1 clears them only when `pme_en` = 0. With `pme_en` = 1, `bus_rst` leaves every bit unchanged.
- R9: In the first cycle after a clearing reset ends, bits 0, 1 and 2 are set if the synchronized `stat_in[0]`, `stat_in[1]` and `stat_in[2]` are 1. Bit 3 is not set. An input level held unchanged across the reset produces no change event afterwards.
- R10: `irq` is registered. After each edge it equals the OR of (event bit AND `int_en` bit) as it stood before that edge, so it stays high until every enabled event bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| glb_rst | input | 1 | Global reset, synchronous, active high |
| bus_rst | input | 1 | Bus reset, synchronous, active high, gated by pme_en |
| pme_en | input | 1 | Power-management event enable; 1 shields the event bits from bus_rst |
| card_16b | input | 1 | 1 = 16-bit card (both edges), 0 = 32-bit card (rising only) |
| stat_in | input | 4 | Asynchronous socket status lines |
| clr_we | input | 1 | Write strobe of the clear port |
| clr_data | input | 32 | Write-one-to-clear data |
| frc_we | input | 1 | Write strobe of the force port |
| frc_data | input | 32 | Write-one-to-set data |
| int_en | input | 4 | Per-bit interrupt enable, 1 = enabled |
| rd_data | output | 32 | Event register read value |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach is a hardware set that lands in exactly the same cycle as a software clear of the same bit. The set arrives only after the synchronizer and edge-detector delay. The bench therefore toggles a card-detect line, counts two edges, and pulses the clear strobe so that it meets the edge on which the set takes effect. A second hard case is the re-arm pulse after a reset. It is reached by holding the status lines at a chosen mix of levels through a bus reset with power management disabled and then through a global reset. The bench then checks that only the level-qualified bits come back and that the power-cycle bit does not.

// File: rtl/sock_evt_pkg.sv
package sock_evt_pkg;
  localparam int EVT_CS  = 0;
  localparam int EVT_CD1 = 1;
  localparam int EVT_CD2 = 2;
  localparam int EVT_PWR = 3;

  typedef enum logic {
    CARD_32B = 1'b0,
    CARD_16B = 1'b1
  } card_kind_e;
endpackage

// File: rtl/sock_evt_sync.sv
module sock_evt_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    stg <= {stg[STAGES-2:0], d_in};
  end

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/sock_evt_edge.sv
module sock_evt_edge
  import sock_evt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  card_kind_e   kind,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;

  // previous value tracks every cycle, including during reset
  always_ff @(posedge clk) begin
    prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == EVT_CS) begin : g_cs
      always_comb begin
        if (kind == CARD_16B) chg[i] = lvl[i] ^ prev_q[i];
        else                  chg[i] = lvl[i] & ~prev_q[i];
      end
    end else begin : g_any
      assign chg[i] = lvl[i] ^ prev_q[i];
    end
  end
endmodule

// File: rtl/sock_evt_bits.sv
module sock_evt_bits #(
  parameter int NE = 4
) (
  input  logic          clk,
  input  logic          evt_rst,
  input  logic [NE-1:0] hw_set,
  input  logic [NE-1:0] sw_set,
  input  logic [NE-1:0] sw_clr,
  input  logic [NE-1:0] rearm,
  output logic [NE-1:0] evt_q
);
  logic [NE-1:0] set_all;

  assign set_all = hw_set | sw_set | rearm;

  always_ff @(posedge clk) begin
    if (evt_rst) evt_q <= '0;
    else         evt_q <= (evt_q & ~sw_clr) | set_all;  // set wins
  end
endmodule

// File: rtl/sock_evt_reg.sv
module sock_evt_reg
  import sock_evt_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_EVT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               glb_rst,
  input  logic               bus_rst,
  input  logic               pme_en,
  input  logic               card_16b,
  input  logic [NUM_EVT-1:0] stat_in,
  input  logic               clr_we,
  input  logic [DATA_W-1:0]  clr_data,
  input  logic               frc_we,
  input  logic [DATA_W-1:0]  frc_data,
  input  logic [NUM_EVT-1:0] int_en,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq
);
  localparam int RSVD_W = DATA_W - NUM_EVT;
  localparam logic [NUM_EVT-1:0] REARM_MASK =
    NUM_EVT'((1 << EVT_CS) | (1 << EVT_CD1) | (1 << EVT_CD2));

  logic               evt_rst;
  logic               evt_rst_q;
  logic [NUM_EVT-1:0] lvl_sync;
  logic [NUM_EVT-1:0] hw_chg;
  logic [NUM_EVT-1:0] sw_set;
  logic [NUM_EVT-1:0] sw_clr;
  logic [NUM_EVT-1:0] rearm;
  logic [NUM_EVT-1:0] evt_q;
  logic               unused_rsvd;

  assign evt_rst = glb_rst | (bus_rst & ~pme_en);

  always_ff @(posedge clk) begin
    evt_rst_q <= evt_rst;
  end

  sock_evt_sync #(.W(NUM_EVT), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .d_in  (stat_in),
    .q_out (lvl_sync)
  );

  sock_evt_edge #(.W(NUM_EVT)) u_edge (
    .clk  (clk),
    .kind (card_kind_e'(card_16b)),
    .lvl  (lvl_sync),
    .chg  (hw_chg)
  );

  assign sw_set = frc_we ? frc_data[NUM_EVT-1:0] : '0;
  assign sw_clr = clr_we ? clr_data[NUM_EVT-1:0] : '0;
  assign rearm  = (evt_rst_q & ~evt_rst) ? (lvl_sync & REARM_MASK) : '0;
  assign unused_rsvd = ^{clr_data[DATA_W-1:NUM_EVT], frc_data[DATA_W-1:NUM_EVT]};

  sock_evt_bits #(.NE(NUM_EVT)) u_bits (
    .clk     (clk),
    .evt_rst (evt_rst),
    .hw_set  (hw_chg),
    .sw_set  (sw_set),
    .sw_clr  (sw_clr),
    .rearm   (rearm),
    .evt_q   (evt_q)
  );

  always_ff @(posedge clk) begin
    if (evt_rst) irq <= 1'b0;
    else         irq <= |(evt_q & int_en);
  end

  assign rd_data = {{RSVD_W{1'b0}}, evt_q};
endmodule

// File: rtl/sock_evt_chk.sv
module sock_evt_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 4
) (
  input logic               clk,
  input logic               glb_rst,
  input logic               bus_rst,
  input logic               pme_en,
  input logic               clr_we,
  input logic               frc_we,
  input logic [DATA_W-1:0]  frc_data,
  input logic [NUM_EVT-1:0] int_en,
  input logic [DATA_W-1:0]  rd_data,
  input logic               irq
);
  logic bus_clear;
  assign bus_clear = bus_rst & ~pme_en;

  AST_FORCE_SETS: assert property (@(posedge clk) disable iff (glb_rst)
    (frc_we && !bus_clear) |=>
      ((rd_data[NUM_EVT-1:0] & $past(frc_data[NUM_EVT-1:0])) == $past(frc_data[NUM_EVT-1:0]))); // R6

  AST_BUS_CLEAR: assert property (@(posedge clk) disable iff (glb_rst)
    bus_clear |=> (rd_data[NUM_EVT-1:0] == '0 && !irq)); // R8

  AST_PME_HOLD: assert property (@(posedge clk) disable iff (glb_rst)
    (bus_rst && pme_en && !clr_we) |=>
      (($past(rd_data[NUM_EVT-1:0]) & ~rd_data[NUM_EVT-1:0]) == '0)); // R8

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (glb_rst)
    !bus_clear |=> (irq == |($past(rd_data[NUM_EVT-1:0]) & $past(int_en)))); // R10
endmodule

bind sock_evt_reg sock_evt_chk #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) chk_i (
  .clk      (clk),
  .glb_rst  (glb_rst),
  .bus_rst  (bus_rst),
  .pme_en   (pme_en),
  .clr_we   (clr_we),
  .frc_we   (frc_we),
  .frc_data (frc_data),
  .int_en   (int_en),
  .rd_data  (rd_data),
  .irq      (irq)
);

// File: tb/sock_evt_reg_tb.sv
module sock_evt_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NE = 4;
  localparam int NVEC = 12;

  // row: {card_16b, stat_in, frc, clr, expected event bits}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 4'b0001, 4'b0000, 4'b0000, 4'b0001},  // R3 rising
    {1'b0, 4'b0000, 4'b0000, 4'b0001, 4'b0000},  // R3 falling ignored, R5 clear
    {1'b1, 4'b0001, 4'b0000, 4'b0000, 4'b0001},  // R4 rising
    {1'b1, 4'b0000, 4'b0000, 4'b0001, 4'b0001},  // R4 falling sets after clear
    {1'b1, 4'b0010, 4'b0000, 4'b0001, 4'b0010},  // R2 cd1
    {1'b1, 4'b0110, 4'b0000, 4'b0000, 4'b0110},  // R2 cd2
    {1'b1, 4'b1110, 4'b0000, 4'b0000, 4'b1110},  // R2 power
    {1'b1, 4'b1110, 4'b0000, 4'b1010, 4'b0100},  // R5 partial clear
    {1'b1, 4'b1110, 4'b1001, 4'b0000, 4'b1101},  // R6 force
    {1'b1, 4'b1110, 4'b0000, 4'b1111, 4'b0000},  // R5 clear all
    {1'b1, 4'b1100, 4'b0000, 4'b0000, 4'b0010},  // R2 cd1 falling
    {1'b0, 4'b1100, 4'b0000, 4'b0010, 4'b0000}   // R5
  };

  logic          clk = 1'b0;
  logic          glb_rst = 1'b1;
  logic          bus_rst = 1'b0;
  logic          pme_en = 1'b0;
  logic          card_16b = 1'b0;
  logic [NE-1:0] stat_in = '0;
  logic          clr_we = 1'b0;
  logic [DW-1:0] clr_data = '0;
  logic          frc_we = 1'b0;
  logic [DW-1:0] frc_data = '0;
  logic [NE-1:0] int_en = '0;
  logic [DW-1:0] rd_data;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sock_evt_reg #(.DATA_W(DW), .NUM_EVT(NE), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .glb_rst(glb_rst), .bus_rst(bus_rst), .pme_en(pme_en),
    .card_16b(card_16b), .stat_in(stat_in), .clr_we(clr_we), .clr_data(clr_data),
    .frc_we(frc_we), .frc_data(frc_data), .int_en(int_en),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse_wr(input logic [DW-1:0] f, input logic [DW-1:0] c);
    frc_we = (f != '0); frc_data = f;
    clr_we = (c != '0); clr_data = c;
    step(1);
    frc_we = 1'b0; frc_data = '0;
    clr_we = 1'b0; clr_data = '0;
  endtask

  initial begin
    step(5);
    chk("R8 reset rd_data", rd_data, '0);
    chk("R10 reset irq", {31'b0, irq}, '0);
    glb_rst = 1'b0;
    step(3);
    chk("R9 quiet inputs", rd_data, '0);

    for (int i = 0; i < NVEC; i++) begin
      card_16b = VEC[i][16];
      stat_in  = VEC[i][15:12];
      pulse_wr({28'b0, VEC[i][11:8]}, {28'b0, VEC[i][7:4]});
      step(2);
      chk($sformatf("R2-5 vector %0d", i), rd_data, {28'b0, VEC[i][3:0]});
    end

    // R7: hardware set meets clear on the same edge
    stat_in[1] = 1'b1;
    step(2);
    pulse_wr('0, 32'h2);
    chk("R7 hw set vs clear", rd_data, 32'h2);
    // R7: force and clear on the same edge
    pulse_wr(32'h1, 32'h1);
    chk("R7 force vs clear", rd_data, 32'h3);

    // R10 interrupt
    step(1);
    chk("R10 irq disabled", {31'b0, irq}, '0);
    int_en = 4'b0100;
    step(1);
    chk("R10 irq other bit", {31'b0, irq}, '0);
    int_en = 4'b0010;
    step(1);
    chk("R10 irq enabled", {31'b0, irq}, 32'h1);
    pulse_wr('0, 32'h3);
    chk("R10 irq registered", {31'b0, irq}, 32'h1);
    chk("R5 cleared", rd_data, '0);
    step(1);
    chk("R10 irq drops", {31'b0, irq}, '0);
    int_en = '0;

    // R1 reserved bits
    pulse_wr(32'hFFFF_FFF0, '0);
    chk("R1 force reserved", rd_data, '0);
    pulse_wr(32'h1, '0);
    pulse_wr('0, 32'hFFFF_FFF0);
    chk("R1 clear reserved", rd_data, 32'h1);
    pulse_wr('0, 32'h1);

    // R8 / R9 reset behaviour
    stat_in = 4'b1101;
    step(3);
    pulse_wr('0, 32'hF);
    chk("R5 clear before reset", rd_data, '0);
    pulse_wr(32'hF, '0);
    chk("R6 force all", rd_data, 32'hF);
    pme_en = 1'b1; bus_rst = 1'b1;
    step(2);
    chk("R8 bus reset shielded", rd_data, 32'hF);
    pme_en = 1'b0;
    step(1);
    chk("R8 bus reset clears", rd_data, '0);
    step(1);
    chk("R8 bus reset held", rd_data, '0);
    bus_rst = 1'b0;
    step(1);
    chk("R9 rearm after bus reset", rd_data, 32'h5);
    pulse_wr(32'hF, '0);
    pme_en = 1'b1; glb_rst = 1'b1;
    step(1);
    chk("R8 global reset clears", rd_data, '0);
    glb_rst = 1'b0;
    step(1);
    chk("R9 rearm after global reset", rd_data, 32'h5);
    step(4);
    chk("R9 no spurious change", rd_data, 32'h5);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule